// File: doc/BRIEF.md
# Programmable Pad I/O Cell

This cell sits between core logic and one bidirectional pad group of `W` bits. On the way out it chooses one of two core words with a per-cycle select, optionally holds the chosen word in an output register, and can flip its polarity before the pad. It can also run a double-rate output: two words are taken together on a rising clock edge, and each drives the pad for one half of the following clock period. The pad enable is worked out from a core enable under one of three polarity modes. It can be registered or passed straight through.

On the way in, the pad is always captured on the rising edge. With double-rate input enabled, it is also captured on the falling edge. A line that carries address in one half-cycle and data in the other is therefore split into two registered words, with no logic needed in the core. All configuration inputs are static mode pins, and they are only changed while reset is held. Reset is synchronous and active high. It clears every register in the cell.

Top module: `io_pad_cell`

## Requirements
- R1: With `cfgOutReg`=0 and `cfgDdrOut`=0, `padOut` equals `coreOutB` when `outSel`=1 and `coreOutA` when `outSel`=0, XORed with the inversion mask, in the same cycle.
- R2: With `cfgOutReg`=1 and `cfgDdrOut`=0, `padOut` shows the selected word that was sampled on the most recent rising edge.
- R3: With `cfgOutInv`=1, every bit of `padOut` is the complement of what it would be with `cfgOutInv`=0, in every output mode.
- R4: `cfgOeMode`=0 drives `padOe` high when `coreOe`=1. `cfgOeMode`=1 drives `padOe` high when `coreOe`=0.
- R5: `cfgOeMode`=2 or 3 holds `padOe` at 1 at all times, during reset as well.
- R6: With `cfgOeReg`=1 in modes 0 and 1, `padOe` follows the polarity-resolved enable with a delay of one rising edge.
- R7: With `cfgDdrOut`=1, `coreOutA` and `coreOutB` are both sampled on the rising edge. `padOut` carries the `coreOutA` word while `clk` is high and the `coreOutB` word while `clk` is low. This setting takes priority over `cfgOutReg`.
- R8: `inRise` holds `padIn` as sampled on the latest rising edge.
- R9: With `cfgDdrIn`=1, `inFall` holds `padIn` as sampled on the latest falling edge. With `cfgDdrIn`=0, `inFall` is 0.
- R10: Reset clears every register. While reset is active, and after it until the next load, the registered output reads as the inversion mask. `inRise` and `inFall` read 0. With a registered enable, the pad is tri-stated unless the mode is always-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, both edges used |
| rst | input | 1 | Synchronous reset, active high |
| cfgOutReg | input | 1 | Register the selected output word |
| cfgOutInv | input | 1 | Invert the word sent to the pad |
| cfgDdrOut | input | 1 | Double-rate output mode |
| cfgOeMode | input | 2 | 0 active-high, 1 active-low, 2/3 always enabled |
| cfgOeReg | input | 1 | Register the pad enable |
| cfgDdrIn | input | 1 | Enable falling-edge input capture |
| coreOutA | input | W | First core output word (rising-half word in DDR) |
| coreOutB | input | W | Second core output word (falling-half word in DDR) |
| outSel | input | 1 | Per-cycle selection of coreOutB over coreOutA |
| coreOe | input | 1 | Core output enable before polarity handling |
| padIn | input | W | Value received from the pad |
| padOut | output | W | Value driven toward the pad |
| padOe | output | 1 | Pad driver enable, 1 drives |
| inRise | output | W | Rising-edge captured input |
| inFall | output | W | Falling-edge captured input |

## Verification
A stale or wrong output register shows on `padOut` at the first rising edge after the bad load, in registered and double-rate modes alike. In double-rate mode, a swapped half-word shows in the very next half-period. A mis-held enable register shows as a wrong `padOe` one edge after the core enable changes. A broken falling-edge capture shows on `inFall` half a period after the pad changes. Because the bench samples every output in both clock phases, and also right after each input change, such faults are seen within one clock period.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

  typedef enum logic [1:0] {
    OE_ACT_HIGH = 2'd0,
    OE_ACT_LOW  = 2'd1,
    OE_ALWAYS   = 2'd2,
    OE_ALWAYS2  = 2'd3
  } oeMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearRegs;
    logic useOutReg;
    logic useDdrOut;
    logic invert;
    logic oeNext;
    logic oeUseReg;
    logic oeForce;
    logic ddrIn;
  } ctrlStrobe_t;

endpackage

// File: rtl/ioc_ctrl.sv
module ioc_ctrl
  import ioc_pkg::*;
(
  input  logic        rst,
  input  logic        cfgOutReg,
  input  logic        cfgOutInv,
  input  logic        cfgDdrOut,
  input  logic [1:0]  cfgOeMode,
  input  logic        cfgOeReg,
  input  logic        cfgDdrIn,
  input  logic        coreOe,
  output ctrlStrobe_t strobe
);

  oeMode_e modeDec;
  logic    oeResolved;
  logic    oeForced;

  assign modeDec = oeMode_e'(cfgOeMode);

  // Polarity resolution of the core enable
  always_comb begin
    oeForced   = 1'b0;
    oeResolved = 1'b1;
    unique case (modeDec)
      OE_ACT_HIGH: oeResolved = coreOe;
      OE_ACT_LOW:  oeResolved = ~coreOe;
      OE_ALWAYS,
      OE_ALWAYS2: begin
        oeResolved = 1'b1;
        oeForced   = 1'b1;
      end
      default:     oeResolved = 1'b0;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.clearRegs = rst;
    // double rate output wins over the plain output register
    strobe.useDdrOut = cfgDdrOut;
    strobe.useOutReg = cfgOutReg & ~cfgDdrOut;
    strobe.invert    = cfgOutInv;
    strobe.oeNext    = oeResolved;
    strobe.oeUseReg  = cfgOeReg & ~oeForced;
    strobe.oeForce   = oeForced;
    strobe.ddrIn     = cfgDdrIn;
  end

endmodule

// File: rtl/ioc_datapath.sv
module ioc_datapath
  import ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  ctrlStrobe_t   strobe,
  input  logic [W-1:0]  coreOutA,
  input  logic [W-1:0]  coreOutB,
  input  logic          outSel,
  input  logic [W-1:0]  padIn,
  output logic [W-1:0]  padOut,
  output logic          padOe,
  output logic [W-1:0]  inRise,
  output logic [W-1:0]  inFall
);

  localparam logic [W-1:0] ZERO_WORD = '0;

  logic [W-1:0] muxWord;
  logic [W-1:0] outReg;
  logic [W-1:0] ddrRiseWord;
  logic [W-1:0] ddrFallWord;
  logic [W-1:0] ddrWord;
  logic [W-1:0] baseWord;
  logic [W-1:0] invMask;
  logic [W-1:0] riseCap;
  logic [W-1:0] fallCap;
  logic         oeReg;

  assign muxWord = outSel ? coreOutB : coreOutA;

  // Rising-edge registers: output, DDR pair, enable, input capture
  always_ff @(posedge clk) begin
    if (strobe.clearRegs) begin
      outReg      <= ZERO_WORD;
      ddrRiseWord <= ZERO_WORD;
      ddrFallWord <= ZERO_WORD;
      oeReg       <= 1'b0;
      riseCap     <= ZERO_WORD;
    end else begin
      outReg      <= muxWord;
      ddrRiseWord <= coreOutA;
      ddrFallWord <= coreOutB;
      oeReg       <= strobe.oeNext;
      riseCap     <= padIn;
    end
  end

  // Falling-edge input capture for the second half of a shared line
  always_ff @(negedge clk) begin
    if (strobe.clearRegs || !strobe.ddrIn) begin
      fallCap <= ZERO_WORD;
    end else begin
      fallCap <= padIn;
    end
  end

  // Per-bit DDR half-period select and inversion
  for (genvar b = 0; b < W; b++) begin : g_lane
    assign ddrWord[b] = clk ? ddrRiseWord[b] : ddrFallWord[b];
    assign invMask[b] = strobe.invert;
  end

  always_comb begin
    if (strobe.useDdrOut) begin
      baseWord = ddrWord;
    end else if (strobe.useOutReg) begin
      baseWord = outReg;
    end else begin
      baseWord = muxWord;
    end
  end

  assign padOut = baseWord ^ invMask;
  assign padOe  = strobe.oeForce | (strobe.oeUseReg ? oeReg : strobe.oeNext);
  assign inRise = riseCap;
  assign inFall = fallCap;

endmodule

// File: rtl/io_pad_cell.sv
module io_pad_cell
  import ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfgOutReg,
  input  logic          cfgOutInv,
  input  logic          cfgDdrOut,
  input  logic [1:0]    cfgOeMode,
  input  logic          cfgOeReg,
  input  logic          cfgDdrIn,
  input  logic [W-1:0]  coreOutA,
  input  logic [W-1:0]  coreOutB,
  input  logic          outSel,
  input  logic          coreOe,
  input  logic [W-1:0]  padIn,
  output logic [W-1:0]  padOut,
  output logic          padOe,
  output logic [W-1:0]  inRise,
  output logic [W-1:0]  inFall
);

  ctrlStrobe_t strobe;

  ioc_ctrl u_ctrl (
    .rst       (rst),
    .cfgOutReg (cfgOutReg),
    .cfgOutInv (cfgOutInv),
    .cfgDdrOut (cfgDdrOut),
    .cfgOeMode (cfgOeMode),
    .cfgOeReg  (cfgOeReg),
    .cfgDdrIn  (cfgDdrIn),
    .coreOe    (coreOe),
    .strobe    (strobe)
  );

  ioc_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .coreOutA (coreOutA),
    .coreOutB (coreOutB),
    .outSel   (outSel),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .inRise   (inRise),
    .inFall   (inFall)
  );

endmodule

// File: rtl/io_pad_cell_chk.sv
module io_pad_cell_chk #(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfgOutReg,
  input logic          cfgOutInv,
  input logic          cfgDdrOut,
  input logic [1:0]    cfgOeMode,
  input logic          cfgOeReg,
  input logic          cfgDdrIn,
  input logic [W-1:0]  coreOutA,
  input logic [W-1:0]  coreOutB,
  input logic          outSel,
  input logic          coreOe,
  input logic [W-1:0]  padIn,
  input logic [W-1:0]  padOut,
  input logic          padOe,
  input logic [W-1:0]  inRise,
  input logic [W-1:0]  inFall
);

  // R5
  oe_always_chk: assert property (@(posedge clk) disable iff (rst)
    cfgOeMode[1] |-> padOe);

  // R6
  oe_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgOeReg && cfgOeMode == 2'd0) |=> (padOe == $past(coreOe)));

  // R2
  out_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgOutReg && !cfgDdrOut) |=>
      (padOut == (($past(outSel) ? $past(coreOutB) : $past(coreOutA)) ^ {W{cfgOutInv}})));

  // R9
  fall_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfgDdrIn && $past(!cfgDdrIn)) |-> (inFall == '0));

  // R10
  reset_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && cfgOeReg && !cfgOeMode[1]) |-> !padOe);

  // R8
  in_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |=> (inRise == $past(padIn)));

endmodule

bind io_pad_cell io_pad_cell_chk #(.W(W)) u_chk (.*);

// File: tb/io_pad_cell_bench.sv
`timescale 1ns/1ps
module io_pad_cell_bench;

  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfgOutReg = 1'b0, cfgOutInv = 1'b0, cfgDdrOut = 1'b0;
  logic [1:0]    cfgOeMode = 2'd0;
  logic          cfgOeReg = 1'b0, cfgDdrIn = 1'b0;
  logic [W-1:0]  coreOutA = '0, coreOutB = '0, padIn = '0;
  logic          outSel = 1'b0, coreOe = 1'b0;
  logic [W-1:0]  padOut, inRise, inFall;
  logic          padOe;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // bench model state
  logic [W-1:0] mOutReg = '0, mRise = '0, mFall = '0, mInRise = '0, mInFall = '0;
  logic         mOe = 1'b0;

  always #2.5 clk = ~clk;

  io_pad_cell #(.W(W)) u_io_pad_cell (
    .clk(clk), .rst(rst), .cfgOutReg(cfgOutReg), .cfgOutInv(cfgOutInv),
    .cfgDdrOut(cfgDdrOut), .cfgOeMode(cfgOeMode), .cfgOeReg(cfgOeReg),
    .cfgDdrIn(cfgDdrIn), .coreOutA(coreOutA), .coreOutB(coreOutB),
    .outSel(outSel), .coreOe(coreOe), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .inRise(inRise), .inFall(inFall)
  );

  function automatic logic [W-1:0] selWord();
    return outSel ? coreOutB : coreOutA;
  endfunction

  function automatic logic oeResolved();
    if (cfgOeMode[1]) return 1'b1;
    return (cfgOeMode == 2'd0) ? coreOe : ~coreOe;
  endfunction

  function automatic logic [W-1:0] expPad(input bit hi);
    logic [W-1:0] base;
    if (cfgDdrOut)      base = hi ? mRise : mFall;
    else if (cfgOutReg) base = mOutReg;
    else                base = selWord();
    return base ^ {W{cfgOutInv}};
  endfunction

  function automatic logic expOe();
    if (cfgOeMode[1]) return 1'b1;
    return cfgOeReg ? mOe : oeResolved();
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input bit hi);
    string rOut, rOe;
    rOut = cfgDdrOut ? "R7" : (cfgOutReg ? "R2" : "R1");
    if (cfgOutInv) rOut = {rOut, "/R3"};
    if (rst && (cfgDdrOut || cfgOutReg)) rOut = {rOut, "/R10"};
    rOe = cfgOeMode[1] ? "R5" : (cfgOeReg ? "R6" : "R4");
    if (rst && cfgOeReg) rOe = {rOe, "/R10"};
    cmp(rOut, "padOut", padOut, expPad(hi));
    cmp(rOe, "padOe", {{(W-1){1'b0}}, padOe}, {{(W-1){1'b0}}, expOe()});
    cmp(rst ? "R8/R10" : "R8", "inRise", inRise, mInRise);
    cmp(rst ? "R9/R10" : "R9", "inFall", inFall, mInFall);
  endtask

  task automatic driveRandom();
    coreOutA = W'($urandom);
    coreOutB = W'($urandom);
    outSel   = 1'($urandom);
    coreOe   = 1'($urandom);
    padIn    = W'($urandom);
  endtask

  task automatic oneCycle();
    @(negedge clk);
    if (rst) mInFall = '0;
    else     mInFall = cfgDdrIn ? padIn : '0;
    #1 checkAll(0);
    driveRandom();
    #0.2 checkAll(0);
    @(posedge clk);
    if (rst) begin
      mOutReg = '0; mRise = '0; mFall = '0; mOe = 1'b0; mInRise = '0;
    end else begin
      mOutReg = selWord(); mRise = coreOutA; mFall = coreOutB;
      mOe = oeResolved(); mInRise = padIn;
    end
    #1 checkAll(1);
    padIn = W'($urandom);
    #0.2 checkAll(1);
  endtask

  task automatic setCfg(input int seg);
    case (seg)
      0: {cfgOutReg, cfgOutInv, cfgDdrOut, cfgOeMode, cfgOeReg, cfgDdrIn} = 7'b0_0_0_00_0_0; // R1 R4
      1: {cfgOutReg, cfgOutInv, cfgDdrOut, cfgOeMode, cfgOeReg, cfgDdrIn} = 7'b1_0_0_01_1_0; // R2 R6 R10
      2: {cfgOutReg, cfgOutInv, cfgDdrOut, cfgOeMode, cfgOeReg, cfgDdrIn} = 7'b1_1_0_10_1_1; // R3 R5 R9
      3: {cfgOutReg, cfgOutInv, cfgDdrOut, cfgOeMode, cfgOeReg, cfgDdrIn} = 7'b0_0_1_00_1_1; // R7 R9
      4: {cfgOutReg, cfgOutInv, cfgDdrOut, cfgOeMode, cfgOeReg, cfgDdrIn} = 7'b1_1_1_11_0_1; // R7 priority, R3
      5: {cfgOutReg, cfgOutInv, cfgDdrOut, cfgOeMode, cfgOeReg, cfgDdrIn} = 7'b0_1_0_01_0_0; // R3 R4
      default: {cfgOutReg, cfgOutInv, cfgDdrOut, cfgOeMode, cfgOeReg, cfgDdrIn} = 7'($urandom);
    endcase
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int seg = 0; seg < 30; seg++) begin
      rst = 1'b1;
      setCfg(seg);
      oneCycle();
      oneCycle();
      // R10: cleared state seen at the ports while reset holds
      cmp("R10", "inRise reset", inRise, '0);
      if (cfgOeReg && !cfgOeMode[1])
        cmp("R10", "padOe reset", {{(W-1){1'b0}}, padOe}, '0);
      if (cfgOeMode[1])
        cmp("R5", "padOe reset", {{(W-1){1'b0}}, padOe}, {{(W-1){1'b0}}, 1'b1});
      rst = 1'b0;
      for (int c = 0; c < 40; c++) oneCycle();
    end
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule